// File: doc/BRIEF.md
# Scan-Testable Modulo-3 Counter

This block is a three-state counter whose two state flip-flops are mux-scan cells linked into one serial chain. In functional mode a count enable moves the state around the cycle 00, 01, 10. A synchronous clear returns it to 00, and a terminal flag marks state 10. In scan mode the chain shifts one bit per clock from a serial input, through both state bits, to a serial output. This lets a tester load any present state, including the unused code 11, and unload the state captured after one functional clock.

The next-state and terminal logic is a pure combinational core with four inputs (enable, clear and the two present-state bits) and three outputs (the terminal flag and the two next-state bits). With the chain in place, that core can be tested exhaustively from the pins by scan load, capture and unload. An active-low asynchronous reset initialises the flops at power-up.

Top module: `mod3_scan_counter`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it rises, the state is 00, so `term` is 0 and `scan_out` is 0.
- R2: With `test_ctl`=1, `clr`=1 sets the state to 00 on the next clock, whatever `cnt_en` and the present state are.
- R3: With `test_ctl`=1, `clr`=0 and `cnt_en`=1, each clock advances the state 00→01→10→00. State is written {Q1,Q2}, with Q1 the most significant bit.
- R4: With `test_ctl`=1 and `clr`=`cnt_en`=0, both state bits keep their values.
- R5: `term` is 1 exactly when the state is 10. It is 0 in states 00, 01 and 11.
- R6: With `test_ctl`=0, each clock loads Q1 from `scan_in` and Q2 from the old Q1. `scan_out` always shows Q2.
- R7: With `test_ctl`=0, `clr` and `cnt_en` have no effect on the state.
- R8: State 11 can be loaded through the chain. From 11, a count step gives 00, and a clear also gives 00.
- R9: `term` follows the present state combinationally. It is valid in the same cycle in which a shifted-in state becomes present, with no extra clock.
- R10: An exhaustive scan test of the core takes exactly 44 clocks, and every captured response appears on `scan_out`. The test is: a six-clock chain flush with the pattern 0,0,1,1,0,0; then, for each of 12 vectors (clear/enable in {00,01,10} × 4 present states), two shift clocks followed by one capture clock; then two final unload clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| cnt_en | input | 1 | Count enable (functional mode) |
| clr | input | 1 | Synchronous clear, has priority over `cnt_en` (functional mode) |
| test_ctl | input | 1 | 1 = functional next state, 0 = serial shift |
| scan_in | input | 1 | Serial chain input, feeds Q1 |
| scan_out | output | 1 | Serial chain output, equals Q2 |
| term | output | 1 | Terminal flag, 1 in state 10 |

## Verification
Assertions check the following on every clock: the clear, the count steps including the wrap from 10 and 11, the hold, the one-place shift in scan mode, and the consistency of `term` with the chain output. Other behaviours need the bench's scenarios against its own cycle model. These are the reset values, inputs being ignored while shifting, the same-cycle `term` after a scan load, and the 44-clock exhaustive scan sequence, in which each captured response is compared as it leaves the chain.

// File: rtl/mod3_scan_pkg.sv
package mod3_scan_pkg;
  localparam int STATE_W = 2;
  typedef logic [STATE_W-1:0] st_t;

  localparam st_t ST_IDLE = 2'b00;
  localparam st_t ST_ONE  = 2'b01;
  localparam st_t ST_TERM = 2'b10;
  localparam st_t ST_SPARE = 2'b11;

  // Next state of the counter core: clear wins, then count, else hold.
  function automatic st_t core_next(input logic en, input logic clear, input st_t pres);
    st_t n;
    if (clear)        n = ST_IDLE;
    else if (!en)     n = pres;
    else begin
      case (pres)
        ST_IDLE: n = ST_ONE;
        ST_ONE:  n = ST_TERM;
        default: n = ST_IDLE; // 10 wraps, spare 11 recovers
      endcase
    end
    return n;
  endfunction

  function automatic logic core_term(input st_t pres);
    return (pres == ST_TERM);
  endfunction
endpackage

// File: rtl/mod3_core.sv
module mod3_core
  import mod3_scan_pkg::*;
(
  input  logic cnt_en,
  input  logic clr,
  input  st_t  pres,
  output st_t  nxt,
  output logic term
);
  always_comb begin
    nxt  = core_next(cnt_en, clr, pres);
    term = core_term(pres);
  end
endmodule

// File: rtl/scan_dff.sv
module scan_dff #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic test_ctl,
  input  logic d,
  input  logic sd,
  output logic q
);
  logic sel_d;
  assign sel_d = test_ctl ? d : sd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= sel_d;
  end
endmodule

// File: rtl/mod3_scan_counter.sv
module mod3_scan_counter
  import mod3_scan_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cnt_en,
  input  logic clr,
  input  logic test_ctl,
  input  logic scan_in,
  output logic scan_out,
  output logic term
);
  st_t state;
  st_t nxt;

  mod3_core u_core (
    .cnt_en(cnt_en),
    .clr   (clr),
    .pres  (state),
    .nxt   (nxt),
    .term  (term)
  );

  // Chain position i: 0 is Q1 (MSB), last is Q2 (LSB).
  for (genvar i = 0; i < STATE_W; i++) begin : g_chain
    localparam int BIT = STATE_W - 1 - i;
    logic sd_w;
    if (i == 0) begin : g_head
      assign sd_w = scan_in;
    end else begin : g_link
      assign sd_w = state[BIT+1];
    end
    scan_dff #(.RST_VAL(ST_IDLE[BIT])) u_sff (
      .clk     (clk),
      .rst_n   (rst_n),
      .test_ctl(test_ctl),
      .d       (nxt[BIT]),
      .sd      (sd_w),
      .q       (state[BIT])
    );
  end

  assign scan_out = state[0];

  // Named events for the checks below.
  logic clr_evt, step_evt, hold_evt, shift_evt;
  assign clr_evt   = test_ctl & clr;
  assign step_evt  = test_ctl & ~clr & cnt_en;
  assign hold_evt  = test_ctl & ~clr & ~cnt_en;
  assign shift_evt = ~test_ctl;

  a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> state == ST_IDLE);

  a_r3_advance_idle: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt && state == ST_IDLE |=> state == ST_ONE);

  a_r3_advance_one: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt && state == ST_ONE |=> state == ST_TERM);

  a_r8_wrap_high: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt && state[STATE_W-1] |=> state == ST_IDLE);

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    hold_evt |=> $stable(state));

  a_r6_shift: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> (state[STATE_W-1] == $past(scan_in)) &&
                  (state[STATE_W-2:0] == $past(state[STATE_W-1:1])));

  a_r5_term_code: assert property (@(posedge clk) disable iff (!rst_n)
    term |-> (state[STATE_W-1] && !scan_out));
endmodule

// File: tb/mod3_scan_counter_test.sv
`timescale 1ns/100ps
module mod3_scan_counter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_en = 1'b0, clr = 1'b0, test_ctl = 1'b1, scan_in = 1'b0;
  logic scan_out, term;

  int checks = 0;
  int fails = 0;
  int model = 0;   // 0..3, bit1 = Q1, bit0 = Q2

  always #2.5 clk = ~clk;

  mod3_scan_counter uut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .clr(clr),
    .test_ctl(test_ctl), .scan_in(scan_in), .scan_out(scan_out), .term(term)
  );

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b (model state %0d)", req, what, act, exp, model);
    end
  endtask

  task automatic compare(input string req);
    check(req, term, (model == 2) ? 1'b1 : 1'b0, "term");
    check(req, scan_out, model[0], "scan_out");
  endtask

  // One clock: drive on falling edge, model at rising edge, compare next falling edge.
  task automatic step(input logic tc, input logic en, input logic cl, input logic si, input string req);
    test_ctl = tc; cnt_en = en; clr = cl; scan_in = si;
    @(posedge clk);
    if (!tc) model = (si ? 2 : 0) + model / 2;
    else if (cl) model = 0;
    else if (en) begin
      if (model == 0) model = 1;
      else if (model == 1) model = 2;
      else model = 0;
    end
    @(negedge clk);
    compare(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int clocks;
    @(negedge clk);
    model = 0;
    compare("R1");                    // during reset
    @(negedge clk);
    rst_n = 1'b1;
    step(1, 0, 0, 0, "R1");

    // R3 / R5: count around twice
    for (int k = 0; k < 6; k++) step(1, 1, 0, 0, "R3_R5");
    step(1, 1, 0, 0, "R3");           // to 01
    step(1, 1, 0, 0, "R3");           // to 10
    // R4: hold in 10
    for (int k = 0; k < 3; k++) step(1, 0, 0, 1, "R4");
    // R2: clear with enable from 10
    step(1, 1, 1, 0, "R2");
    step(1, 1, 0, 0, "R3");
    step(1, 1, 1, 1, "R2");

    // R6 / R9: load 10 via chain; term valid right after last shift
    step(0, 0, 0, 0, "R6");
    step(0, 0, 0, 1, "R9");
    // R7: shifting with clr and cnt_en high; inputs ignored
    step(0, 1, 1, 1, "R7");
    step(0, 1, 1, 0, "R7");
    step(0, 1, 0, 1, "R7");
    // R8: load 11, count -> 00
    step(0, 0, 0, 1, "R8");
    step(0, 0, 0, 1, "R8");
    step(1, 1, 0, 0, "R8");
    // R8: load 11, clear -> 00
    step(0, 0, 0, 1, "R8");
    step(0, 0, 0, 1, "R8");
    step(1, 0, 1, 0, "R8");

    // R10: exhaustive scan test of the core
    clocks = 0;
    begin
      logic flush [6] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
      for (int k = 0; k < 6; k++) begin
        step(0, 0, 0, flush[k], "R10");
        clocks++;
      end
    end
    for (int v = 0; v < 12; v++) begin
      int p, ctl;
      p = v % 4;
      ctl = v / 4;                    // 0: hold, 1: count, 2: clear
      step(0, 0, 0, p[0], "R10");     // lands in Q2
      step(0, 0, 0, p[1], "R10");     // lands in Q1
      clocks += 2;
      step(1, ctl == 1, ctl == 2, 0, "R10");
      clocks++;
    end
    step(0, 0, 0, 0, "R10");
    step(0, 0, 0, 0, "R10");
    clocks += 2;
    checks++;
    if (clocks != 44) begin
      fails++;
      $display("FAIL R10 scan length: actual %0d expected 44", clocks);
    end

    // R1 again: asynchronous reset from a nonzero state
    step(0, 0, 0, 1, "R1");
    rst_n = 1'b0;
    #1;
    model = 0;
    compare("R1");
    @(negedge clk);
    rst_n = 1'b1;
    step(1, 0, 0, 0, "R1");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule